// File: doc/BRIEF.md
# AUX Request Header Formatter

This block sits between a requester that issues DisplayPort AUX transactions and the byte transport that carries them. When started, it captures a 20-bit address, a 4-bit request code, a payload size and up to sixteen payload bytes. It builds a four-byte request header and streams it out on a byte-wide valid/ready port. For writes, the payload bytes follow the header.

After the last byte leaves, the block accepts the reply as a stream of bytes. The first byte is the status. The data bytes that follow are marked by a last flag on the final byte. The block classifies the status, keeps the read data it is allowed to keep, and reports the result with a single-cycle done pulse. The result is an error code, a reply nibble and a byte count.

Malformed requests are rejected on the cycle after start, and nothing is transmitted. A request is malformed when its code is not a read or a write, or when its size exceeds the limit for its direction.

Top module: `aux_hdr_fmt`

## Requirements
- R1: Header byte 0 carries address bits 7:0. Header byte 1 carries address bits 15:8. Header byte 2 carries the request code (as given, including bit 2) in bits 7:4 and address bits 19:16 in bits 3:0. Write payload byte i is taken from wr_data bits 8i+7:8i and sent after the header in ascending order.
- R2: Bits 3:0 of header byte 3 hold the size minus one, or 0 when the size is 0.
- R3: Bits 7:4 of header byte 3 depend on the request. They are 3 when the size is 0. They are 4 for a read with nonzero size. They are (4 + size) modulo 16 for a write with nonzero size, so a 12-byte write shows 0. A read sends exactly the 4 header bytes. A write sends 4 + size bytes.
- R4: The request kind is decided by the code with bit 2 cleared. Kinds 0, 2 and 8 are writes. Kinds 1 and 9 are reads. Any other kind is rejected with err=4, len=0 and reply=0, and the done pulse comes one cycle after start with no byte sent.
- R5: A write larger than 12 bytes or a read larger than 16 bytes is rejected with err=3, len=0 and reply=0 in the same way.
- R6: A status byte of exactly 1 gives err=1 (timeout). A status byte of exactly 2 or 3 gives err=2 (I/O failure). In all three cases len=0, reply=0, and no reply data is stored.
- R7: Any other status byte is a success with err=0, and reply equals status bits 7:4.
- R8: On a successful read, data byte k after the status lands in rd_data bits 8k+7:8k. len is the number of data bytes received, clamped to the requested size. Surplus bytes are dropped. rd_data is cleared when a request is accepted.
- R9: On a successful write, len equals the payload size, whatever the number of reply data bytes.
- R10: busy is 0 after reset and rises on the cycle after an accepted start. It stays high until the done pulse, which lasts one cycle with busy already low. A start while busy is ignored.
- R11: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data stays unchanged. rx_ready is high only while the reply is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled when idle |
| req_code | input | 4 | Request code |
| req_addr | input | 20 | Target address |
| req_size | input | 5 | Payload size or read size in bytes |
| wr_data | input | 128 | Write payload, byte i at bits 8i+7:8i |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Transport accepts outgoing byte |
| rx_ready | output | 1 | Block accepts reply bytes |
| rx_valid | input | 1 | Reply byte valid |
| rx_data | input | 8 | Reply byte; the first one is the status |
| rx_last | input | 1 | Marks the final reply byte |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 3 | 0 ok, 1 timeout, 2 I/O, 3 too big, 4 invalid |
| reply | output | 4 | Reply nibble on success |
| len | output | 5 | Result byte count |
| rd_data | output | 128 | Stored read data |

## Verification
Some properties are checked by assertions on every cycle:
- byte hold under backpressure;
- done only while idle;
- a start during a request leaving the captured request untouched;
- the next-cycle rejection of bad codes and oversize requests;
- zero counts on error statuses;
- the read clamp.

Other behaviour can only be shown by the bench's scenarios, which run a step-by-step reference model alongside the block:
- the exact header bytes, including the wrapped high nibble of a 12-byte write and the value 3 for bare-address packets;
- the payload order;
- the reply nibble;
- the drop of surplus read bytes.

// File: rtl/aux_hdr_fmt.sv
module aux_hdr_fmt #(
  parameter int MAX_RD = 16,
  parameter int MAX_WR = 12,
  parameter int SZW    = $clog2(MAX_RD + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [3:0]            req_code,
  input  logic [19:0]           req_addr,
  input  logic [SZW-1:0]        req_size,
  input  logic [8*MAX_RD-1:0]   wr_data,
  output logic                  tx_valid,
  output logic [7:0]            tx_data,
  input  logic                  tx_ready,
  output logic                  rx_ready,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_data,
  input  logic                  rx_last,
  output logic                  busy,
  output logic                  done,
  output logic [2:0]            err,
  output logic [3:0]            reply,
  output logic [SZW-1:0]        len,
  output logic [8*MAX_RD-1:0]   rd_data
);
  localparam int IW = SZW + 1;
  localparam logic [2:0] E_OK = 3'd0, E_TMO = 3'd1, E_IO = 3'd2, E_BIG = 3'd3, E_INV = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_TX, S_RX} st_t;
  st_t st;

  logic [3:0]          code_q;
  logic [19:0]         addr_q;
  logic [SZW-1:0]      size_q;
  logic                rd_q;
  logic [8*MAX_RD-1:0] pay_q;
  logic [IW-1:0]       idx;
  logic                first_q;
  logic [7:0]          sts_q;
  logic [SZW-1:0]      cnt;

  logic [3:0] kind;
  logic       k_wr, k_rd, bad_code, too_big;
  assign kind     = req_code & 4'hB;
  assign k_wr     = (kind == 4'h0) || (kind == 4'h2) || (kind == 4'h8);
  assign k_rd     = (kind == 4'h1) || (kind == 4'h9);
  assign bad_code = !(k_wr || k_rd);
  assign too_big  = k_wr ? (int'(req_size) > MAX_WR) : (int'(req_size) > MAX_RD);

  logic [3:0]    hi_n, lo_n;
  logic [IW-1:0] tx_len, pidx;
  logic [8*MAX_RD-1:0] pay_sh;
  assign hi_n   = (size_q == '0) ? 4'd3 : rd_q ? 4'd4 : 4'(4'd4 + 4'(size_q));
  assign lo_n   = (size_q == '0) ? 4'd0 : 4'(size_q - 1'b1);
  assign tx_len = rd_q ? IW'(4) : IW'(4) + IW'(size_q);
  assign pidx   = idx - IW'(4);
  assign pay_sh = pay_q >> {pidx, 3'b000};

  always_comb begin
    case (idx)
      IW'(0):  tx_data = addr_q[7:0];
      IW'(1):  tx_data = addr_q[15:8];
      IW'(2):  tx_data = {code_q, addr_q[19:16]};
      IW'(3):  tx_data = {hi_n, lo_n};
      default: tx_data = pay_sh[7:0];
    endcase
  end

  assign tx_valid = (st == S_TX);
  assign rx_ready = (st == S_RX);
  assign busy     = (st != S_IDLE);

  logic [7:0] sts_now;
  logic       sts_ok, store;
  assign sts_now = first_q ? rx_data : sts_q;
  assign sts_ok  = !(sts_now == 8'd1 || sts_now == 8'd2 || sts_now == 8'd3);
  assign store   = !first_q && sts_ok && rd_q && (cnt < size_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      code_q <= '0; addr_q <= '0; size_q <= '0; rd_q <= 1'b0; pay_q <= '0;
      idx <= '0; first_q <= 1'b1; sts_q <= '0; cnt <= '0;
      done <= 1'b0; err <= E_OK; reply <= '0; len <= '0; rd_data <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (bad_code || too_big) begin
            done  <= 1'b1;
            err   <= bad_code ? E_INV : E_BIG;
            reply <= '0;
            len   <= '0;
          end else begin
            st      <= S_TX;
            code_q  <= req_code;
            addr_q  <= req_addr;
            size_q  <= req_size;
            rd_q    <= k_rd;
            pay_q   <= wr_data;
            idx     <= '0;
            first_q <= 1'b1;
            cnt     <= '0;
            rd_data <= '0;
          end
        end
        S_TX: if (tx_ready) begin
          idx <= idx + 1'b1;
          if (idx == tx_len - 1'b1) st <= S_RX;
        end
        S_RX: if (rx_valid) begin
          if (first_q) begin
            sts_q   <= rx_data;
            first_q <= 1'b0;
          end
          for (int i = 0; i < MAX_RD; i++)
            if (store && int'(cnt) == i) rd_data[i*8 +: 8] <= rx_data;
          if (store) cnt <= cnt + 1'b1;
          if (rx_last) begin
            st    <= S_IDLE;
            done  <= 1'b1;
            err   <= (sts_now == 8'd1) ? E_TMO : sts_ok ? E_OK : E_IO;
            reply <= sts_ok ? sts_now[7:4] : 4'd0;
            len   <= !sts_ok ? '0 : rd_q ? (cnt + SZW'(store)) : size_q;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(code_q) && $stable(size_q) && $stable(addr_q)));
  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  a_r4_reject_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && bad_code) |=> (done && err == E_INV && !tx_valid));
  a_r5_reject_size: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !bad_code && too_big) |=> (done && err == E_BIG && !tx_valid));
  a_r6_err_nodata: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (err == E_TMO || err == E_IO)) |-> (len == '0 && reply == 4'd0));
  a_r8_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == E_OK && rd_q) |-> (len <= size_q));
endmodule

// File: tb/aux_hdr_fmt_test.sv
module aux_hdr_fmt_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [3:0] req_code = 0;
  logic [19:0] req_addr = 0;
  logic [4:0] req_size = 0;
  logic [127:0] wr_data = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
  logic tx_ready = 0, rx_valid = 0, rx_last = 0;
  logic [7:0] rx_data = 0;
  logic tx_valid, rx_ready, busy, done;
  logic [7:0] tx_data;
  logic [2:0] err;
  logic [3:0] reply;
  logic [4:0] len;
  logic [127:0] rd_data;

  aux_hdr_fmt uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_code(req_code), .req_addr(req_addr),
    .req_size(req_size), .wr_data(wr_data), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .busy(busy), .done(done), .err(err), .reply(reply), .len(len),
    .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // reference model
  int m_st = 0, m_idx = 0, m_size = 0, m_sts = 0, m_cnt = 0;
  bit m_rd = 0, m_first = 1, m_done = 0;
  int m_err = 0, m_reply = 0, m_len = 0;
  logic [127:0] m_rdd = 0;
  byte unsigned q[$];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_done = 0; m_err = 0; m_reply = 0; m_len = 0; m_rdd = 0; q.delete();
    end else begin
      m_done = 0;
      if (m_st == 0 && start) begin
        int k, hi, lo;
        bit w, r;
        k = req_code & 4'hB;
        w = (k == 0 || k == 2 || k == 8);
        r = (k == 1 || k == 9);
        if (!w && !r) begin
          m_done = 1; m_err = 4; m_reply = 0; m_len = 0;
        end else if ((w && req_size > 12) || (r && req_size > 16)) begin
          m_done = 1; m_err = 3; m_reply = 0; m_len = 0;
        end else begin
          m_size = req_size; m_rd = r; m_first = 1; m_cnt = 0; m_rdd = 0; m_idx = 0;
          hi = (m_size == 0) ? 3 : r ? 4 : (4 + m_size) % 16;
          lo = (m_size == 0) ? 0 : m_size - 1;
          q.delete();
          q.push_back(req_addr[7:0]);
          q.push_back(req_addr[15:8]);
          q.push_back({req_code, req_addr[19:16]});
          q.push_back(8'(hi * 16 + lo));
          if (w) for (int i = 0; i < m_size; i++) q.push_back(wr_data[i*8 +: 8]);
          m_st = 1;
        end
      end else if (m_st == 1 && tx_ready) begin
        void'(q.pop_front());
        m_idx++;
        if (q.size() == 0) m_st = 2;
      end else if (m_st == 2 && rx_valid) begin
        bit ok;
        if (m_first) begin m_sts = rx_data; m_first = 0; end
        else begin
          ok = !(m_sts == 1 || m_sts == 2 || m_sts == 3);
          if (ok && m_rd && m_cnt < m_size) begin
            m_rdd[m_cnt*8 +: 8] = rx_data;
            m_cnt++;
          end
        end
        if (rx_last) begin
          ok = !(m_sts == 1 || m_sts == 2 || m_sts == 3);
          m_st = 0; m_done = 1;
          m_err = (m_sts == 1) ? 1 : ok ? 0 : 2;
          m_reply = ok ? (m_sts >> 4) : 0;
          m_len = !ok ? 0 : m_rd ? m_cnt : m_size;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  bit rst_checked = 0;
  always @(negedge clk) if (rst_n) begin
    if (!rst_checked) begin
      rst_checked = 1;
      chk(busy === 0 && done === 0 && err === 0 && len === 0 && tx_valid === 0, "R10 reset state",
          {busy, done, err, len, tx_valid}, 0);
    end
    chk(busy === (m_st != 0), "R10 busy", busy, m_st != 0);
    chk(tx_valid === (m_st == 1), "R3/R11 tx_valid", tx_valid, m_st == 1);
    chk(rx_ready === (m_st == 2), "R11 rx_ready", rx_ready, m_st == 2);
    chk(done === m_done, "R10 done", done, m_done);
    if (m_st == 1 && q.size() > 0)
      chk(tx_data === q[0], (m_idx == 3) ? "R2/R3 count byte" : "R1 header/payload byte", tx_data, q[0]);
    if (m_done) begin
      chk(err === 3'(m_err), (m_err == 3) ? "R5 err" : (m_err == 4) ? "R4 err" : "R6 err", err, m_err);
      chk(reply === 4'(m_reply), "R7 reply", reply, m_reply);
      chk(len === 5'(m_len), (m_err != 0) ? "R6 len" : m_rd ? "R8 len" : "R9 len", len, m_len);
      chk(rd_data === m_rdd, "R8 rd_data", rd_data[63:0], m_rdd[63:0]);
    end
  end

  task automatic run(input logic [3:0] code, input logic [19:0] addr, input int size,
                     input logic [7:0] sts, input int nrx, input bit mid_start);
    int k = 0;
    @(negedge clk);
    req_code = code; req_addr = addr; req_size = 5'(size); start = 1;
    @(negedge clk);
    start = 0;
    while (!rx_ready && !done && k < 100) begin
      tx_ready = (k % 3 != 2);
      if (mid_start && k == 2) begin start = 1; req_code = 4'h9; req_size = 5'd2; end
      else start = 0;
      k++;
      @(negedge clk);
    end
    start = 0; tx_ready = 0;
    if (done) begin @(negedge clk); return; end
    for (int j = 0; j <= nrx; j++) begin
      rx_valid = 1; rx_data = (j == 0) ? sts : 8'(8'hA0 + j); rx_last = (j == nrx);
      @(negedge clk);
      if (j % 3 == 2 && j != nrx) begin rx_valid = 0; @(negedge clk); end
    end
    rx_valid = 0; rx_last = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    run(4'h8, 20'hABCDE, 3, 8'h00, 0, 0);   // R1 R2 R3 R9 native write
    run(4'h9, 20'h12345, 5, 8'h00, 7, 0);   // R8 clamp 7 -> 5
    run(4'h9, 20'h00200, 4, 8'h20, 2, 0);   // R7 R8 short read
    run(4'h1, 20'h00050, 0, 8'h00, 1, 0);   // R3 bare read
    run(4'h4, 20'h00050, 0, 8'h10, 0, 0);   // R3 R4 bare write with bit 2
    run(4'h0, 20'hF0F0F, 12, 8'h00, 0, 0);  // R3 wrapped nibble
    run(4'h2, 20'h00033, 1, 8'h00, 3, 0);   // R9 write ignores data
    run(4'hC, 20'h00033, 4, 8'h00, 0, 0);   // R4 native write with bit 2
    run(4'h0, 20'h00001, 13, 8'h00, 0, 0);  // R5 write too big
    run(4'h9, 20'h00001, 17, 8'h00, 0, 0);  // R5 read too big
    run(4'h9, 20'h00100, 16, 8'h00, 16, 0); // R8 full read
    run(4'h3, 20'h00001, 1, 8'h00, 0, 0);   // R4 invalid
    run(4'hA, 20'h00001, 1, 8'h00, 0, 0);   // R4 invalid
    run(4'h9, 20'h00400, 3, 8'h01, 2, 0);   // R6 timeout
    run(4'h8, 20'h00400, 3, 8'h02, 0, 0);   // R6 flags
    run(4'h9, 20'h00400, 3, 8'h03, 3, 0);   // R6 error
    run(4'h9, 20'h00400, 3, 8'h45, 3, 0);   // R7 other status ok
    run(4'h8, 20'h77777, 6, 8'h00, 0, 1);   // R10 start while busy ignored
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule